// File: doc/BRIEF.md
# Bit-Interleaved E1 Transmit Demultiplexer

This block takes a single high-rate serial line, clocked at 16.384 MHz, that carries the transmit payload of four E1 channels. The channels are interleaved one bit at a time, and filler positions pad each group. It splits the line back into one 2.048 Mbit/s bit stream per channel. An external sync pulse fixes where the multiplexed frame begins. The sender must line its serial data up with that pulse. The block does not look inside the bits: framing, signalling and payload reach each channel unaltered, and the downstream per-channel logic deals with them.

Each 2.048 MHz bit period holds eight input cycles, called slots. In slot `c`, for `c` below the channel count, the line carries one bit of channel `c`. The remaining slots are filler and are dropped. For each channel the block registers the bit and raises a one-cycle valid strobe. It also raises a start-of-frame flag on the channel's bit 0 of its 256-bit frame.

The output stream has a valid strobe and no ready signal. The line runs at a fixed rate and cannot be stalled, so there is no back-pressure. A consumer must take each bit in the cycle its strobe is high. After the strobe, the bit stays on the output for the rest of the 2.048 MHz period.

Top module: `e1_tdm_demux`

## Requirements
- R1: While `rst_ni` is low at a rising edge, the next cycle shows `ch_data_o`, `ch_valid_o`, `ch_sof_o` and `misalign_o` all at 0.
- R2: After reset and before the first cycle with `sync_i` high, no bit of `ch_valid_o` or `ch_sof_o` rises, whatever `ser_i` carries.
- R3: A cycle with `sync_i` high is slot 0 of frame bit 0. Its `ser_i` value appears on `ch_data_o[0]` in the next cycle, with `ch_valid_o[0]` and `ch_sof_o[0]` both high.
- R4: Once locked, the bit sampled in slot `c` (0 to NUM_CH-1, counted from the last sync) appears on `ch_data_o[c]` one cycle later, with `ch_valid_o[c]` high for that cycle only. At most one valid bit is high in any cycle.
- R5: Bits in slots NUM_CH to SLOTS-1 (4 to 7 by default) are filler. They never change any `ch_data_o` bit and never raise a valid strobe.
- R6: Each channel's data bit holds its value for the SLOTS-1 cycles between its strobes. The channel's valid strobe pulses exactly once every SLOTS cycles.
- R7: The frame is FRAME_BITS bits long (256 by default). With no further sync, the bit counter wraps from FRAME_BITS-1 to 0, so `ch_sof_o[c]` pulses once every SLOTS*FRAME_BITS cycles, always together with `ch_valid_o[c]`.
- R8: A sync pulse that falls exactly where slot 0 of bit 0 is expected, or the first sync after reset, leaves `misalign_o` low.
- R9: A sync pulse that falls at any other position raises `misalign_o` for exactly one cycle, the cycle after the sync. The counters realign at once, so the sync cycle's bit goes to channel 0 as frame bit 0.
- R10: A reset in the middle of operation returns the block to hunting: no strobes until the next sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz line clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sync_i | input | 1 | Frame sync; high marks slot 0 of frame bit 0 |
| ser_i | input | 1 | Bit-interleaved serial line |
| ch_data_o | output | NUM_CH | Per-channel recovered bit, held for one channel bit period |
| ch_valid_o | output | NUM_CH | Per-channel one-cycle strobe at the 2.048 MHz rate |
| ch_sof_o | output | NUM_CH | Per-channel strobe on frame bit 0 |
| misalign_o | output | 1 | One-cycle pulse after a sync at an unexpected position |

## Verification
The bench builds the block with its default parameters: four channels, eight slots per bit and a 256-bit frame. At these values a full frame is only 2048 cycles. That makes it practical to run through a natural wrap of the bit counter, to see the frame flag recur without any sync, and then to place a sync exactly on the boundary. The same setting places every filler slot, an early sync, and a reset during operation within short directed sequences. A cycle-by-cycle model in the bench predicts all four outputs.

// File: rtl/e1dmx_pkg.sv
package e1dmx_pkg;
  localparam int unsigned DEF_CH     = 4;
  localparam int unsigned DEF_SLOTS  = 8;
  localparam int unsigned DEF_FRAME  = 256;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_e;
endpackage

// File: rtl/e1dmx_slot_ctr.sv
module e1dmx_slot_ctr
  import e1dmx_pkg::*;
#(
  parameter int unsigned SLOTS      = DEF_SLOTS,
  parameter int unsigned FRAME_BITS = DEF_FRAME,
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  output logic [SW-1:0] cur_slot_o,
  output logic          first_bit_o,
  output logic          live_o,
  output logic          misalign_o
);
  lock_e         state_q;
  logic [SW-1:0] slot_q, slot_nxt;
  logic [BW-1:0] bit_q, bit_cur, bit_nxt;
  logic          misalign_q, misalign_d;

  // Position of the present cycle: a sync forces slot 0 / bit 0.
  always_comb begin
    cur_slot_o  = sync_i ? '0 : slot_q;
    bit_cur     = sync_i ? '0 : bit_q;
    live_o      = sync_i | (state_q == ST_LOCK);
    first_bit_o = (bit_cur == '0);
    misalign_d  = sync_i && (state_q == ST_LOCK) &&
                  ((slot_q != '0) || (bit_q != '0));
  end

  always_comb begin
    if (cur_slot_o == SW'(SLOTS - 1)) begin
      slot_nxt = '0;
      bit_nxt  = (bit_cur == BW'(FRAME_BITS - 1)) ? '0 : bit_cur + 1'b1;
    end else begin
      slot_nxt = cur_slot_o + 1'b1;
      bit_nxt  = bit_cur;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      slot_q     <= '0;
      bit_q      <= '0;
      misalign_q <= 1'b0;
    end else begin
      misalign_q <= misalign_d;
      if (live_o) begin
        state_q <= ST_LOCK;
        slot_q  <= slot_nxt;
        bit_q   <= bit_nxt;
      end
    end
  end

  assign misalign_o = misalign_q;
endmodule

// File: rtl/e1dmx_lane.sv
module e1dmx_lane #(
  parameter int unsigned SW       = 3,
  parameter int unsigned LANE_IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          live_i,
  input  logic [SW-1:0] slot_i,
  input  logic          first_bit_i,
  input  logic          ser_i,
  output logic          data_o,
  output logic          valid_o,
  output logic          sof_o
);
  logic hit;
  assign hit = live_i && (slot_i == SW'(LANE_IDX));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      data_o  <= 1'b0;
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
    end else begin
      valid_o <= hit;
      sof_o   <= hit && first_bit_i;
      if (hit) data_o <= ser_i;
    end
  end
endmodule

// File: rtl/e1_tdm_demux.sv
module e1_tdm_demux
  import e1dmx_pkg::*;
#(
  parameter int unsigned NUM_CH     = DEF_CH,
  parameter int unsigned SLOTS      = DEF_SLOTS,
  parameter int unsigned FRAME_BITS = DEF_FRAME
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              ser_i,
  output logic [NUM_CH-1:0] ch_data_o,
  output logic [NUM_CH-1:0] ch_valid_o,
  output logic [NUM_CH-1:0] ch_sof_o,
  output logic              misalign_o
);
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SW-1:0] cur_slot;
  logic          first_bit;
  logic          live;

  e1dmx_slot_ctr #(
    .SLOTS      (SLOTS),
    .FRAME_BITS (FRAME_BITS)
  ) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .cur_slot_o  (cur_slot),
    .first_bit_o (first_bit),
    .live_o      (live),
    .misalign_o  (misalign_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    e1dmx_lane #(
      .SW       (SW),
      .LANE_IDX (c)
    ) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .live_i      (live),
      .slot_i      (cur_slot),
      .first_bit_i (first_bit),
      .ser_i       (ser_i),
      .data_o      (ch_data_o[c]),
      .valid_o     (ch_valid_o[c]),
      .sof_o       (ch_sof_o[c])
    );
  end
endmodule

// File: rtl/e1_tdm_demux_chk.sv
module e1_tdm_demux_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              ser_i,
  input logic [NUM_CH-1:0] ch_data_o,
  input logic [NUM_CH-1:0] ch_valid_o,
  input logic [NUM_CH-1:0] ch_sof_o,
  input logic              misalign_o
);
  logic seen_sync;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) seen_sync <= 1'b0;
    else         seen_sync <= seen_sync | sync_i;
  end

  p_hunt_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_sync && !sync_i) |=> (ch_valid_o == '0));

  p_sync_slot0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (ch_valid_o[0] && ch_sof_o[0] && (ch_data_o[0] == $past(ser_i))));

  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_valid_o));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ch_data_o & ~ch_valid_o) == ($past(ch_data_o) & ~ch_valid_o)));

  p_sof_in_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ch_sof_o & ~ch_valid_o) == '0));

  p_misalign_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> $past(sync_i));

  p_misalign_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !misalign_o);
endmodule

bind e1_tdm_demux e1_tdm_demux_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .ser_i      (ser_i),
  .ch_data_o  (ch_data_o),
  .ch_valid_o (ch_valid_o),
  .ch_sof_o   (ch_sof_o),
  .misalign_o (misalign_o)
);

// File: tb/test_e1_tdm_demux.sv
`timescale 1ns/1ps
module test_e1_tdm_demux;
  localparam int NCH = 4;
  localparam int NSL = 8;
  localparam int NFB = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic ser = 1'b0;
  logic [NCH-1:0] d_o, v_o, s_o;
  logic mis_o;

  always #5 clk = ~clk;

  e1_tdm_demux #(.NUM_CH(NCH), .SLOTS(NSL), .FRAME_BITS(NFB)) i_e1_tdm_demux (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .ser_i(ser),
    .ch_data_o(d_o), .ch_valid_o(v_o), .ch_sof_o(s_o), .misalign_o(mis_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the expected behaviour
  bit m_lock;
  int m_slot, m_bit;
  logic [NCH-1:0] e_d, e_v, e_s;
  logic e_m;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_lock = 0; m_slot = 0; m_bit = 0;
    e_d = '0; e_v = '0; e_s = '0; e_m = 1'b0;
  endtask

  // one line cycle: drive, clock, compare with the model
  task automatic step(input bit s, input bit d);
    int cs, cb;
    bit lk, was_lock;
    @(negedge clk);
    sync = s; ser = d;
    cs = s ? 0 : m_slot;
    cb = s ? 0 : m_bit;
    was_lock = m_lock;
    lk = m_lock | s;
    e_m = s && m_lock && !(m_slot == 0 && m_bit == 0);
    for (int c = 0; c < NCH; c++) begin
      if (lk && cs == c) begin
        e_d[c] = d; e_v[c] = 1'b1; e_s[c] = (cb == 0);
      end else begin
        e_v[c] = 1'b0; e_s[c] = 1'b0;
      end
    end
    if (cs == NSL - 1) begin
      m_slot = 0;
      m_bit = (cb == NFB - 1) ? 0 : cb + 1;
    end else begin
      m_slot = cs + 1;
      m_bit = cb;
    end
    m_lock = lk;
    @(posedge clk); #1;
    chk(lk ? "R4 valid" : "R2 valid", 32'(v_o), 32'(e_v));
    chk(s ? "R3 data" : "R4/R5/R6 data", 32'(d_o), 32'(e_d));
    chk("R7 sof", 32'(s_o), 32'(e_s));
    chk(was_lock ? "R9 misalign" : "R8 misalign", 32'(mis_o), 32'(e_m));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; sync = 1'b0; ser = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    model_clear();
    chk("R1 data", 32'(d_o), 0);
    chk("R1 valid", 32'(v_o), 0);
    chk("R1 sof", 32'(s_o), 0);
    chk("R1 misalign", 32'(mis_o), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_hunt();
    int strobes = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'(($urandom) & 1));
      if (v_o != 0) strobes++;
    end
    chk("R2 no strobe while hunting", 32'(strobes), 0);
  endtask

  task automatic t_first_sync();
    step(1'b1, 1'b1);
    chk("R3 ch0 strobe", 32'(v_o), 32'h1);
    chk("R3 ch0 data", 32'(d_o[0]), 1);
    chk("R3 ch0 sof", 32'(s_o), 32'h1);
    chk("R8 first sync no misalign", 32'(mis_o), 0);
    // rest of the bit period: ch1..3 get 0,1,1; filler toggles
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk("R4 ch3 data", 32'(d_o), 32'hD);
    for (int i = 0; i < 4; i++) step(1'b0, 1'(i & 1));
  endtask

  task automatic t_filler();
    int strobes = 0;
    // 4 bit periods: channel slots carry 0, filler slots carry 1
    for (int b = 0; b < 4; b++)
      for (int sl = 0; sl < NSL; sl++) begin
        step(1'b0, (sl >= NCH));
        if (sl >= NCH && v_o != 0) strobes++;
      end
    chk("R5 filler data", 32'(d_o), 0);
    chk("R5 filler strobes", 32'(strobes), 0);
  endtask

  task automatic t_wrap();
    int sofs = 0, v0 = 0;
    // walk to the frame boundary, then count over exactly one frame
    while (!(m_slot == 0 && m_bit == 0)) step(1'b0, 1'(($urandom) & 1));
    for (int i = 0; i < NSL * NFB; i++) begin
      step(1'b0, 1'(($urandom) & 1));
      if (s_o[0]) sofs++;
      if (v_o[0]) v0++;
    end
    chk("R7 one sof per frame", 32'(sofs), 1);
    chk("R6 one strobe per bit period", 32'(v0), NFB);
    step(1'b1, 1'b0);
    chk("R8 sync on boundary", 32'(mis_o), 0);
    for (int i = 0; i < NSL - 1; i++) step(1'b0, 1'b1);
  endtask

  task automatic t_misalign();
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R9 misalign raised", 32'(mis_o), 1);
    chk("R9 realign to ch0", 32'(v_o), 32'h1);
    step(1'b0, 1'b0);
    chk("R9 pulse one cycle", 32'(mis_o), 0);
    chk("R9 next slot ch1", 32'(v_o), 32'h2);
    for (int i = 0; i < 14; i++) step(1'b0, 1'(i & 1));
  endtask

  task automatic t_reset_mid();
    int strobes = 0;
    t_reset();
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1);
      if (v_o != 0) strobes++;
    end
    chk("R10 hunting after reset", 32'(strobes), 0);
    step(1'b1, 1'b0);
    chk("R10 relock on sync", 32'(v_o), 32'h1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    t_reset();
    t_hunt();
    t_first_sync();
    t_filler();
    t_wrap();
    t_misalign();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule